// File: doc/BRIEF.md
# Write-Protection Command Sequencer

This block sits on the byte-load path of a page-mode nonvolatile memory and decides, load by load, whether a data-altering operation may proceed. A single protection flag covers the whole array. While the flag is clear, ordinary loads pass straight through as write permits. While it is set, a byte write or a chip-erase request is granted only when a three-byte unlock prefix comes directly before it. A refused write starts a timed lockout, and every load that arrives during the lockout is dropped.

The same three-byte prefix sets the flag when it is loaded, and the write that follows is granted. Clearing the flag needs a separate six-byte sequence. Command bytes are consumed by the sequencer and never produce a write permit. The load interface is a valid/ready stream. `ld_ready` is held high at all times, so a source never stalls: a load offered during lockout is accepted and then discarded. The permit side is a registered one-cycle pulse, `wr_go`, that carries the granted address, data and operation. It has no back-pressure, so the array controller must take every pulse.

Commands are recognised on address bits [14:0] only. Two command addresses are used: CA = 5555h and CB = 2AAAh. A load with `ld_erase` high never counts as a command byte.

Top module: `sdp_gate`

## Requirements
- R1: After reset, `prot_on`, `lockout` and `wr_go` are all 0.
- R2: With protection clear, any load that is not a command byte produces `wr_go`=1 in the next cycle, and `wr_addr`, `wr_data` and `wr_erase` carry that load's values.
- R3: The prefix (CA/AAh, CB/55h, CA/A0h) sets `prot_on` in the cycle after its third byte. The next accepted load is then granted, even while protection is set.
- R4: With protection set, a write without the prefix gives no `wr_go`. `lockout` then goes high in the next cycle and stays high for exactly LOCK_CYC cycles.
- R5: Loads accepted while `lockout` is high are ignored. They produce no permit and do not advance any sequence, so a prefix sent during lockout does not arm a later write.
- R6: The six-byte sequence (CA/AAh, CB/55h, CA/80h, CA/AAh, CB/55h, CA/20h) clears `prot_on` in the cycle after its sixth byte.
- R7: A load that breaks a sequence at any step returns the sequencer to idle and counts as a write attempt. It is granted when protection is clear and causes a lockout when protection is set.
- R8: A chip-erase load (`ld_erase`=1) is gated exactly like a byte write and is reported on `wr_erase`. Such a load is never treated as a command byte.
- R9: Protection is global. Once it is set, an unprefixed write to any address is refused.
- R10: Command bytes never produce `wr_go`, and `ld_ready` is always 1.
- R11: One prefix grants exactly one write. The next write while protected needs a new prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Byte-load offered |
| ld_ready | output | 1 | Load accepted (always 1) |
| ld_addr | input | ADDR_W | Load address |
| ld_data | input | 8 | Load data |
| ld_erase | input | 1 | Load is a chip-erase request |
| wr_go | output | 1 | One-cycle write/erase permit |
| wr_addr | output | ADDR_W | Granted address |
| wr_data | output | 8 | Granted data |
| wr_erase | output | 1 | Granted operation is chip erase |
| prot_on | output | 1 | Global protection flag |
| lockout | output | 1 | Refused-write lockout active |

## Verification
The assertions check several rules on every cycle. No permit can appear during or right after lockout. A lockout starts only from a load made while protected, and it always lasts LOCK_CYC cycles. The flag can only rise on an A0h load and only fall on a 20h load, and neither edge comes with a permit. Other behaviour depends on the order of loads, and only the bench's scenarios can show it: that a prefix grants exactly one write, that a broken sequence at each of the five steps becomes a write attempt, that a prefix sent during lockout is discarded, and the full data sweep with protection clear.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int CMD_AW = 15;
  localparam logic [CMD_AW-1:0] ADDR_CA = 15'h5555;
  localparam logic [CMD_AW-1:0] ADDR_CB = 15'h2AAA;
  localparam logic [7:0] BYTE_KEY1  = 8'hAA;
  localparam logic [7:0] BYTE_KEY2  = 8'h55;
  localparam logic [7:0] BYTE_ARM   = 8'hA0;
  localparam logic [7:0] BYTE_DPRE  = 8'h80;
  localparam logic [7:0] BYTE_CLEAR = 8'h20;

  typedef enum logic [2:0] {
    TK_NONE, TK_KEY1, TK_KEY2, TK_ARM, TK_DPRE, TK_CLEAR
  } tok_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_ARMED, ST_D3, ST_D4, ST_D5
  } seq_t;
endpackage

// File: rtl/sdp_cmd_match.sv
module sdp_cmd_match
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic              erase,
  output tok_t              tok
);
  logic [CMD_AW-1:0] low;

  generate
    if (ADDR_W >= CMD_AW) begin : g_wide
      assign low = addr[CMD_AW-1:0];
    end else begin : g_narrow
      assign low = {{(CMD_AW-ADDR_W){1'b0}}, addr};
    end
  endgenerate

  always_comb begin
    tok = TK_NONE;
    if (!erase) begin
      if (low == ADDR_CA) begin
        case (data)
          BYTE_KEY1:  tok = TK_KEY1;
          BYTE_ARM:   tok = TK_ARM;
          BYTE_DPRE:  tok = TK_DPRE;
          BYTE_CLEAR: tok = TK_CLEAR;
          default:    tok = TK_NONE;
        endcase
      end else if (low == ADDR_CB && data == BYTE_KEY2) begin
        tok = TK_KEY2;
      end
    end
  end
endmodule

// File: rtl/sdp_seq_fsm.sv
module sdp_seq_fsm
  import sdp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  tok_t tok,
  output logic prot_on,
  output logic go_c,
  output logic deny_c
);
  seq_t st, st_nxt;
  logic prot_nxt;
  logic attempt;

  always_comb begin
    st_nxt   = st;
    prot_nxt = prot_on;
    attempt  = 1'b0;
    go_c     = 1'b0;
    deny_c   = 1'b0;
    if (accept) begin
      case (st)
        ST_IDLE: begin
          if (tok == TK_KEY1) st_nxt = ST_U1;
          else attempt = 1'b1;
        end
        ST_U1: begin
          if (tok == TK_KEY2) st_nxt = ST_U2;
          else attempt = 1'b1;
        end
        ST_U2: begin
          if (tok == TK_ARM) begin
            st_nxt   = ST_ARMED;
            prot_nxt = 1'b1;
          end else if (tok == TK_DPRE) begin
            st_nxt = ST_D3;
          end else begin
            attempt = 1'b1;
          end
        end
        ST_ARMED: begin
          st_nxt = ST_IDLE;
          go_c   = 1'b1;
        end
        ST_D3: begin
          if (tok == TK_KEY1) st_nxt = ST_D4;
          else attempt = 1'b1;
        end
        ST_D4: begin
          if (tok == TK_KEY2) st_nxt = ST_D5;
          else attempt = 1'b1;
        end
        ST_D5: begin
          if (tok == TK_CLEAR) begin
            st_nxt   = ST_IDLE;
            prot_nxt = 1'b0;
          end else begin
            attempt = 1'b1;
          end
        end
        default: st_nxt = ST_IDLE;
      endcase
      if (attempt) begin
        st_nxt = ST_IDLE;
        if (prot_on) deny_c = 1'b1;
        else         go_c   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      prot_on <= 1'b0;
    end else begin
      st      <= st_nxt;
      prot_on <= prot_nxt;
    end
  end
endmodule

// File: rtl/sdp_lock_timer.sv
module sdp_lock_timer #(
  parameter int LOCK_CYC = 37500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(LOCK_CYC + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CNT_W'(LOCK_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/sdp_gate.sv
module sdp_gate
  import sdp_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int LOCK_CYC = 37500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              ld_erase,
  output logic              wr_go,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_erase,
  output logic              prot_on,
  output logic              lockout
);
  tok_t tok;
  logic accept, go_c, deny_c;

  assign ld_ready = 1'b1;
  assign accept   = ld_valid && !lockout;

  sdp_cmd_match #(.ADDR_W(ADDR_W)) u_match (
    .addr (ld_addr),
    .data (ld_data),
    .erase(ld_erase),
    .tok  (tok)
  );

  sdp_seq_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .tok    (tok),
    .prot_on(prot_on),
    .go_c   (go_c),
    .deny_c (deny_c)
  );

  sdp_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(deny_c),
    .busy (lockout)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_go    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_erase <= 1'b0;
    end else begin
      wr_go <= go_c;
      if (go_c) begin
        wr_addr  <= ld_addr;
        wr_data  <= ld_data;
        wr_erase <= ld_erase;
      end
    end
  end
endmodule

// File: rtl/sdp_gate_chk.sv
module sdp_gate_chk #(
  parameter int ADDR_W   = 17,
  parameter int LOCK_CYC = 37500
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_valid,
  input logic [7:0] ld_data,
  input logic       ld_erase,
  input logic       wr_go,
  input logic       prot_on,
  input logic       lockout
);
  logic [31:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)       run <= '0;
    else if (lockout) run <= run + 1;
    else              run <= '0;
  end

  assert_lock_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |=> !wr_go);

  assert_go_unlocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> !lockout);

  assert_lock_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lockout) |-> (run == LOCK_CYC));

  assert_lock_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockout) |-> ($past(prot_on) && $past(ld_valid) && !wr_go));

  assert_enable_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> ($past(ld_valid) && $past(ld_data) == 8'hA0
                        && !$past(ld_erase) && !wr_go));

  assert_disable_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> ($past(ld_valid) && $past(ld_data) == 8'h20
                        && !$past(ld_erase) && !wr_go));
endmodule

bind sdp_gate sdp_gate_chk #(.ADDR_W(ADDR_W), .LOCK_CYC(LOCK_CYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ld_valid(ld_valid),
  .ld_data (ld_data),
  .ld_erase(ld_erase),
  .wr_go   (wr_go),
  .prot_on (prot_on),
  .lockout (lockout)
);

// File: tb/sdp_gate_tb.sv
`timescale 1ns/1ps
module sdp_gate_tb;
  localparam int AW = 17;
  localparam int LK = 8;

  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, ld_erase = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic ld_ready, wr_go, wr_erase, prot_on, lockout;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;

  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  sdp_gate #(.ADDR_W(AW), .LOCK_CYC(LK)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .ld_erase(ld_erase),
    .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_erase(wr_erase), .prot_on(prot_on), .lockout(lockout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic put(input logic [AW-1:0] a, input logic [7:0] d, input logic e);
    ld_valid = 1; ld_addr = a; ld_data = d; ld_erase = e;
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic put_nogo(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    put(a, d, 0);
    chk(wr_go == 0, tag, wr_go, 0);
  endtask

  task automatic prefix(input string tag);
    put_nogo(17'h05555, 8'hAA, tag);
    put_nogo(17'h02AAA, 8'h55, tag);
    put_nogo(17'h05555, 8'hA0, tag);
  endtask

  task automatic wait_clear(input string tag);
    int n = 0;
    while (lockout) begin n++; @(negedge clk); end
    chk(n == LK, tag, n, LK);
  endtask

  function automatic logic [AW-1:0] dis_a(input int i);
    return (i == 1 || i == 4) ? 17'h02AAA : 17'h05555;
  endfunction
  function automatic logic [7:0] dis_d(input int i);
    case (i) 0: return 8'hAA; 1: return 8'h55; 2: return 8'h80;
             3: return 8'hAA; 4: return 8'h55; default: return 8'h20; endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state, R10 ready
    chk(prot_on == 0, "R1 prot_on", prot_on, 0);
    chk(lockout == 0, "R1 lockout", lockout, 0);
    chk(wr_go == 0, "R1 wr_go", wr_go, 0);
    chk(ld_ready == 1, "R10 ld_ready", ld_ready, 1);

    // R2 data sweep while unprotected
    for (int d = 0; d < 256; d++) begin
      logic [AW-1:0] a;
      a = 17'h10000 | AW'(d * 37);
      put(a, 8'(d), 0);
      chk(wr_go == 1 && wr_data == 8'(d) && wr_addr == a && wr_erase == 0,
          "R2 pass-through", {wr_go, wr_data}, {1'b1, 8'(d)});
    end

    // R8 erase load never a command byte
    put(17'h05555, 8'hAA, 1);
    chk(wr_go == 1 && wr_erase == 1, "R8 erase unprotected", {wr_go, wr_erase}, 3);

    // R3 enable prefix; R10 command bytes give no permit
    prefix("R10 command byte");
    chk(prot_on == 1, "R3 prot set", prot_on, 1);
    put(17'h00777, 8'h3C, 0);
    chk(wr_go == 1 && wr_data == 8'h3C, "R3 armed write", {wr_go, wr_data}, 9'h13C);
    // R11 second write needs its own prefix; R4 lockout
    put(17'h00778, 8'h11, 0);
    chk(wr_go == 0 && lockout == 1, "R11 refused", {wr_go, lockout}, 1);
    wait_clear("R4 lockout length");

    // R5 loads during lockout ignored
    put(17'h00100, 8'h01, 0);
    chk(lockout == 1, "R4 lockout start", lockout, 1);
    prefix("R5 ignored byte");
    put(17'h00101, 8'h02, 0);
    chk(wr_go == 0, "R5 write in lockout", wr_go, 0);
    while (lockout) @(negedge clk);
    put(17'h00102, 8'h03, 0);
    chk(wr_go == 0 && lockout == 1, "R5 prefix not kept", {wr_go, lockout}, 1);
    wait_clear("R4 lockout length");

    // R9 global protection across addresses
    for (int i = 0; i < 16; i++) begin
      logic [AW-1:0] a;
      a = AW'(i * 32'h2000 + 7);
      prefix("R9 prefix");
      put(a, 8'(i), 0);
      chk(wr_go == 1 && wr_addr == a, "R9 armed write", wr_go, 1);
      put(a ^ 17'h00040, 8'(i + 1), 0);
      chk(wr_go == 0 && lockout == 1, "R9 unprefixed refused", {wr_go, lockout}, 1);
      while (lockout) @(negedge clk);
    end

    // R8 erase gated when protected
    prefix("R8 prefix");
    put(17'h00000, 8'h00, 1);
    chk(wr_go == 1 && wr_erase == 1, "R8 armed erase", {wr_go, wr_erase}, 3);
    put(17'h00000, 8'h00, 1);
    chk(wr_go == 0 && lockout == 1, "R8 erase refused", {wr_go, lockout}, 1);
    wait_clear("R4 lockout length");

    // R7 broken disable sequence while protected
    for (int p = 1; p <= 5; p++) begin
      for (int i = 0; i < p; i++) put_nogo(dis_a(i), dis_d(i), "R10 disable byte");
      put(17'h00123, 8'h5A, 0);
      chk(wr_go == 0 && lockout == 1 && prot_on == 1, "R7 break protected",
          {wr_go, lockout, prot_on}, 3);
      while (lockout) @(negedge clk);
    end

    // R6 full disable
    for (int i = 0; i < 6; i++) put_nogo(dis_a(i), dis_d(i), "R10 disable byte");
    chk(prot_on == 0, "R6 prot cleared", prot_on, 0);
    put(17'h00456, 8'h77, 0);
    chk(wr_go == 1 && wr_data == 8'h77, "R6 write after disable", wr_go, 1);

    // R7 broken sequence while unprotected becomes a write
    for (int p = 1; p <= 5; p++) begin
      for (int i = 0; i < p; i++) put_nogo(dis_a(i), dis_d(i), "R10 disable byte");
      put(17'h00123, 8'h5A, 0);
      chk(wr_go == 1 && wr_data == 8'h5A && prot_on == 0, "R7 break unprotected",
          {wr_go, wr_data}, 9'h15A);
    end
    chk(ld_ready == 1, "R10 ld_ready end", ld_ready, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule